// File: doc/BRIEF.md
# MDIO Pad Front End

This block sits between the MDIO and MDC pads of a PHY-side management interface and the management state machine. It runs only on the fast system clock (125 MHz in the target, so 8 ns per cycle). It never uses MDC as a clock. MDC and MDIO each pass through a synchronizer chain of the same depth, so the two samples taken in any one cycle come from the same instant at the pads. When the synchronized MDC goes from low to high, the block raises a single-cycle strobe. In that same cycle it presents the MDIO level sampled alongside the first high MDC sample. The station only holds MDIO valid for roughly 10 ns on either side of the MDC rising edge, so this alignment is what makes the capture work.

In the other direction, the state machine asks for a drive level and a drive enable. The block moves both through one shared delay line before they reach the pad. The delay gives an external bidirectional level shifter time to change direction before the line is driven. A delay of two cycles adds about 16 ns, which is small next to the roughly 300 ns allowed after an MDC rising edge before driven data must be valid. Each pad output has exactly one driver. Reset clears every stage of the delay line, so the pad is released.

Top module: `mdio_pad_frontend`

## Requirements
- R1: `mdio_pad_o` and `mdio_pad_oe_o` equal `drv_dat_i` and `drv_en_i` as sampled exactly OUT_DELAY (default 2) clock edges earlier. Both pad signals change on the same edge.
- R2: While `rst_ni` is low, and for the first OUT_DELAY edges after it rises, `mdio_pad_oe_o` and `mdio_pad_o` are 0 whatever the requests are.
- R3: Each low-to-high MDC transition gives exactly one `mdc_rise_o` pulse, one clock wide. Each high-to-low MDC transition gives none.
- R4: When `mdc_rise_o` is high, `mdio_bit_o` equals the MDIO level sampled on the same clock edge as the first high MDC sample. A value held only 10 ns either side of the MDC rise is captured correctly.
- R5: Between strobes, `mdio_bit_o` holds its value. MDIO changes while MDC is steady or falling are ignored.
- R6: `mdc_rise_o` is high in the cycle that follows the (SYNC_STAGES+1)-th clock edge. Counting starts at the first edge that samples MDC high, which is edge 1. With the defaults this is 3 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mdc_pad_i | input | 1 | Asynchronous MDC level from the pad |
| mdio_pad_i | input | 1 | Asynchronous MDIO level from the pad |
| drv_dat_i | input | 1 | Requested drive level from the management logic |
| drv_en_i | input | 1 | Requested drive enable from the management logic |
| mdio_pad_o | output | 1 | Delayed drive level to the pad buffer |
| mdio_pad_oe_o | output | 1 | Delayed drive enable to the pad buffer (1 = drive) |
| mdc_rise_o | output | 1 | One-cycle strobe per MDC rising edge |
| mdio_bit_o | output | 1 | Captured MDIO bit, valid with the strobe and held until the next one |

## Verification
The bench builds the block with SYNC_STAGES = 2 and OUT_DELAY = 2. At these values the three-edge strobe latency and the two-edge pad lag can be checked cycle by cycle against fixed bench constants. With a 5 ns bench clock, a 10 ns window on each side of the MDC rise is two cycles. This puts the narrowest legal MDIO valid window within reach of the bench, while MDC keeps a period above 400 ns.

// File: rtl/mdio_pad_pkg.sv
package mdio_pad_pkg;

   // One pad drive request: enable plus level, kept together so they move as one
   typedef struct packed {
      logic en;
      logic dat;
   } pad_drv_t;

   localparam pad_drv_t PAD_RELEASED = '{en: 1'b0, dat: 1'b0};

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mdio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mdio_rise_capture.sv
module mdio_rise_capture (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic mdc_s_i,
   input  logic mdio_s_i,
   output logic rise_o,
   output logic bit_o
);

   logic mdc_prev_q;
   logic rise_now;

   assign rise_now = mdc_s_i & ~mdc_prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mdc_prev_q <= 1'b0;
         rise_o     <= 1'b0;
         bit_o      <= 1'b0;
      end else begin
         mdc_prev_q <= mdc_s_i;
         rise_o     <= rise_now;
         if (rise_now) bit_o <= mdio_s_i;
      end
   end

endmodule

// File: rtl/mdio_drive_delay.sv
module mdio_drive_delay
   import mdio_pad_pkg::*;
#(
   parameter int DEPTH = 2
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  pad_drv_t req_i,
   output pad_drv_t pad_o
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("mdio_drive_delay: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      pad_drv_t stage_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) stage_q <= PAD_RELEASED;
         else         stage_q <= req_i;
      end
      assign pad_o = stage_q;
   end else begin : g_chain
      pad_drv_t stage_q [DEPTH];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int k = 0; k < DEPTH; k++) stage_q[k] <= PAD_RELEASED;
         end else begin
            stage_q[0] <= req_i;
            for (int k = 1; k < DEPTH; k++) stage_q[k] <= stage_q[k-1];
         end
      end
      assign pad_o = stage_q[DEPTH-1];
   end

endmodule

// File: rtl/mdio_pad_frontend.sv
module mdio_pad_frontend
   import mdio_pad_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int OUT_DELAY   = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic mdc_pad_i,
   input  logic mdio_pad_i,
   input  logic drv_dat_i,
   input  logic drv_en_i,
   output logic mdio_pad_o,
   output logic mdio_pad_oe_o,
   output logic mdc_rise_o,
   output logic mdio_bit_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("mdio_pad_frontend: SYNC_STAGES must be at least 2");
   end
   if (OUT_DELAY < 1) begin : g_bad_delay
      $error("mdio_pad_frontend: OUT_DELAY must be at least 1");
   end

   logic     mdc_s;
   logic     mdio_s;
   pad_drv_t req;
   pad_drv_t pad;

   // Equal-depth chains keep the MDIO sample aligned with the MDC sample
   mdio_sync #(.STAGES(SYNC_STAGES)) u_sync_mdc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (mdc_pad_i),
      .q_o    (mdc_s)
   );

   mdio_sync #(.STAGES(SYNC_STAGES)) u_sync_mdio (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (mdio_pad_i),
      .q_o    (mdio_s)
   );

   mdio_rise_capture u_capture (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mdc_s_i  (mdc_s),
      .mdio_s_i (mdio_s),
      .rise_o   (mdc_rise_o),
      .bit_o    (mdio_bit_o)
   );

   assign req.en  = drv_en_i;
   assign req.dat = drv_dat_i;

   mdio_drive_delay #(.DEPTH(OUT_DELAY)) u_delay (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req),
      .pad_o  (pad)
   );

   // Sole drivers of the pad signals
   assign mdio_pad_o    = pad.dat;
   assign mdio_pad_oe_o = pad.en;

endmodule

// File: rtl/mdio_pad_frontend_chk.sv
module mdio_pad_frontend_chk #(
   parameter int OUT_DELAY = 2
) (
   input logic clk_i,
   input logic rst_ni,
   input logic drv_dat_i,
   input logic drv_en_i,
   input logic mdio_pad_o,
   input logic mdio_pad_oe_o,
   input logic mdc_rise_o,
   input logic mdio_bit_o
);

   // Reference shadow of the requests, one entry per cycle of lag
   logic [OUT_DELAY-1:0] en_sh;
   logic [OUT_DELAY-1:0] dat_sh;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_sh  <= '0;
         dat_sh <= '0;
      end else begin
         for (int k = OUT_DELAY - 1; k > 0; k--) begin
            en_sh[k]  <= en_sh[k-1];
            dat_sh[k] <= dat_sh[k-1];
         end
         en_sh[0]  <= drv_en_i;
         dat_sh[0] <= drv_dat_i;
      end
   end

   AST_OE_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mdio_pad_oe_o == en_sh[OUT_DELAY-1]); // R1

   AST_DAT_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mdio_pad_o == dat_sh[OUT_DELAY-1]); // R1

   AST_RESET_RELEASED: assert property (@(posedge clk_i)
      !rst_ni |-> !mdio_pad_oe_o); // R2

   AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mdc_rise_o |=> !mdc_rise_o); // R3

   AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mdc_rise_o |-> $stable(mdio_bit_o)); // R5

endmodule

bind mdio_pad_frontend mdio_pad_frontend_chk #(.OUT_DELAY(OUT_DELAY)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .drv_dat_i     (drv_dat_i),
   .drv_en_i      (drv_en_i),
   .mdio_pad_o    (mdio_pad_o),
   .mdio_pad_oe_o (mdio_pad_oe_o),
   .mdc_rise_o    (mdc_rise_o),
   .mdio_bit_o    (mdio_bit_o)
);

// File: tb/mdio_pad_frontend_tb_top.sv
`timescale 1ns/1ps
module mdio_pad_frontend_tb_top;

   localparam int LAG      = 2;   // OUT_DELAY
   localparam int RISE_LAT = 3;   // SYNC_STAGES + 1
   localparam int NBITS    = 32;
   localparam int HI_CYC   = 44;
   localparam int LO_CYC   = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic mdc = 1'b0, mdio = 1'b0, dat = 1'b0, en = 1'b0;
   logic pad_o, pad_oe, rise, bit_o;

   int checks = 0, fails = 0;
   int rises = 0;
   logic exp_bits [NBITS];
   logic prev_rise = 1'b0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   mdio_pad_frontend #(.SYNC_STAGES(2), .OUT_DELAY(LAG)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .mdc_pad_i(mdc), .mdio_pad_i(mdio),
      .drv_dat_i(dat), .drv_en_i(en), .mdio_pad_o(pad_o),
      .mdio_pad_oe_o(pad_oe), .mdc_rise_o(rise), .mdio_bit_o(bit_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic rnd_bit();
      return logic'($urandom_range(1, 0));
   endfunction

   // Strobe monitor: bit value (R4) and pulse width (R3)
   always @(negedge clk) begin
      if (rst_n && rise) begin
         chk(!prev_rise, "R3 strobe width", int'(prev_rise), 0);
         if (rises < NBITS)
            chk(bit_o == exp_bits[rises], "R4 captured bit", int'(bit_o), int'(exp_bits[rises]));
         rises++;
      end
      prev_rise <= rise;
   end

   initial begin
      int unsigned seed_v;
      logic p1_en, p1_dat, p2_en, p2_dat;
      seed_v = $urandom(32'h1F2E3D4C);
      #1 rst_n = 1'b0;
      // R2: requests asserted while in reset must not reach the pad
      repeat (4) begin
         @(negedge clk);
         en = 1'b1; dat = 1'b1;
         chk(pad_oe == 1'b0, "R2 oe in reset", int'(pad_oe), 0);
         chk(pad_o == 1'b0, "R2 data in reset", int'(pad_o), 0);
      end
      @(negedge clk);
      en = 1'b0; dat = 1'b0;
      p1_en = 0; p1_dat = 0; p2_en = 0; p2_dat = 0;
      rst_n = 1'b1;
      // R1: directed toggles then constrained random requests
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         chk(pad_oe == p2_en, "R1 oe lag", int'(pad_oe), int'(p2_en));
         chk(pad_o == p2_dat, "R1 data lag", int'(pad_o), int'(p2_dat));
         p2_en = p1_en; p2_dat = p1_dat;
         if (i < 8)       begin en = ~en; dat = 1'b1; end
         else if (i < 16) begin en = 1'b1; dat = ~dat; end
         else if (i < 24) begin en = ~en; dat = ~dat; end
         else begin
            en = ($urandom_range(3, 0) != 0) ? ~en : en;
            dat = rnd_bit();
         end
         p1_en = en; p1_dat = dat;
      end
      @(negedge clk); en = 1'b0; dat = 1'b0;
      // MDC phase: each bit valid only 10 ns either side of the rising edge
      for (int b = 0; b < NBITS; b++) begin
         logic v;
         logic held;
         int base;
         if (b < 4)      v = 1'b0;
         else if (b < 8) v = 1'b1;
         else if (b < 16) v = logic'(b[0]);
         else            v = rnd_bit();
         exp_bits[b] = v;
         @(negedge clk); mdio = v;
         repeat (2) @(negedge clk);
         base = rises;
         mdc = 1'b1;
         for (int c = 1; c <= RISE_LAT; c++) begin
            @(negedge clk);
            if (c == 2) mdio = ~v;
            chk(rise == (c == RISE_LAT), "R6 strobe latency", int'(rise), int'(c == RISE_LAT));
         end
         held = bit_o;
         for (int c = 0; c < HI_CYC; c++) begin
            @(negedge clk);
            if ((c % 3) == 0) mdio = rnd_bit();
         end
         mdc = 1'b0;
         for (int c = 0; c < LO_CYC; c++) begin
            @(negedge clk);
            if ((c % 2) == 0) mdio = rnd_bit();
         end
         chk(bit_o == held, "R5 bit held", int'(bit_o), int'(held));
         chk(rises == base + 1, "R3 one strobe per edge", rises - base, 1);
      end
      repeat (6) @(negedge clk);
      chk(rises == NBITS, "R3 total strobes", rises, NBITS);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog R3 actual=%0d expected=%0d", rises, NBITS);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule